// File: doc/BRIEF.md
# Write-Only Serial Command Register Slave

This block is a slave on a two-wire serial bus that only accepts writes. A fast system clock samples the clock line and the data line, and the block finds the bus conditions from those samples. When a frame carries its own address, the block takes in one or more command bytes and pulls the data line low in each acknowledge slot. The last complete command byte waits in a holding register. It is copied into the live command register only when the frame ends with a STOP.

The live register drives three controls:

- a run/shutdown output, which is also gated by an external shutdown pin;
- a bass-boost enable;
- a 6-bit volume code.

A read request to the block's address still gets its address acknowledged. After that the block leaves the data line released, so the master reads all ones. The data line is modelled as open-drain: the block only drives a pull-low enable, and the board supplies the wired-AND.

Top module: `cmdreg_i2c_slave`

## Requirements
- R1: After reset the command register is 8'h00. `shutdown_o` is 1, `bass_en_o` is 0, `volume_o` is 0 and `sda_drive_low_o` is 0.
- R2: The block acknowledges an address byte when its upper seven bits equal the selected address: 7'b1001100 when ADDR_SEL=0, 7'b1001101 when ADDR_SEL=1. It pulls the data line low for the whole high period of the 9th clock pulse.
- R3: An address byte that does not match gets no acknowledge. The block then stays off the data line until the next START, and the command register is unchanged.
- R4: After a write address (bit 0 = 0), every following byte is shifted in MSB first and acknowledged on its 9th pulse.
- R5: The command register changes only when a STOP is recognized (SDA rising while SCL is high). Before that STOP the outputs keep their old values.
- R6: When a frame carries several data bytes, the last complete one is committed at STOP.
- R7: A matching address with bit 0 = 1 is acknowledged. After that the data line stays released until the frame ends, so the master reads ones, and the register is unchanged.
- R8: A repeated START (SDA falling while SCL is high) restarts address reception and discards any uncommitted byte.
- R9: A STOP at any bit position ends the frame. A partial byte, or a frame with only an address, commits nothing, and the next frame works normally.
- R10: A STOP that falls in the same SCL high pulse as the START before it is ignored, and address reception goes on.
- R11: Command bit 7 is the run enable, bit 6 is bass boost and bits 5:0 are the volume (0 = mute, 63 = loudest). `shutdown_o` is 0 only when bit 7 is 1 and `shdn_pin_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| shdn_pin_i | input | 1 | External shutdown pin, low forces shutdown |
| shutdown_o | output | 1 | 1 when the amplifier must be shut down |
| bass_en_o | output | 1 | Bass-boost enable |
| volume_o | output | 6 | Volume code, 0 = mute |

## Verification
A START detection and a STOP detection can both happen inside one SCL high pulse. Only the START may take effect, because the STOP has to be suppressed. The bench raises SCL, drops SDA, then raises SDA again before SCL falls. It then sends a full frame. The frame only commits if the block stayed in address reception, so the committed outputs show whether the same-pulse STOP was ignored.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int CMD_W  = 8;
    localparam int VOL_W  = 6;
    localparam int CNT_W  = $clog2(CMD_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RELEASE
    } slv_state_e;

    typedef struct packed {
        slv_state_e         state;
        logic [CNT_W-1:0]   bits;
        logic [CMD_W-1:0]   shift;
        logic [CMD_W-1:0]   pend;
        logic               pend_vld;
        logic [CMD_W-1:0]   cmd;
        logic               drive;
        logic               rd;
    } slv_regs_t;

endpackage

// File: rtl/cmdreg_line_sync.sv
module cmdreg_line_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/cmdreg_cond_detect.sv
module cmdreg_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_raw,
    output logic stop_ok,
    output logic in_start_pulse
);
    typedef struct packed {
        logic scl;
        logic sda;
        logic hold;
    } det_regs_t;

    det_regs_t det_q, det_d;

    always_comb begin
        det_d     = det_q;
        det_d.scl = scl_s;
        det_d.sda = sda_s;
        if (start_evt) begin
            det_d.hold = 1'b1;
        end else if (!scl_s) begin
            det_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '{scl: 1'b1, sda: 1'b1, hold: 1'b0};
        end else begin
            det_q <= det_d;
        end
    end

    assign scl_rise       = scl_s && !det_q.scl;
    assign scl_fall       = !scl_s && det_q.scl;
    assign start_evt      = scl_s && det_q.scl && det_q.sda && !sda_s;
    assign stop_raw       = scl_s && det_q.scl && !det_q.sda && sda_s;
    assign stop_ok        = stop_raw && !det_q.hold;
    assign in_start_pulse = det_q.hold;
endmodule

// File: rtl/cmdreg_i2c_slave.sv
module cmdreg_i2c_slave
    import cmdreg_pkg::*;
#(
    parameter bit ADDR_SEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_drive_low_o,
    input  logic             shdn_pin_i,
    output logic             shutdown_o,
    output logic             bass_en_o,
    output logic [VOL_W-1:0] volume_o
);
    localparam logic [6:0]       OWN_ADDR  = ADDR_SEL ? 7'b1001101 : 7'b1001100;
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(CMD_W - 1);

    logic [2:0] lines_s;
    logic       scl_s, sda_s, pin_s;
    logic       scl_rise, scl_fall, start_evt, stop_raw, stop_ok, in_start_pulse;

    cmdreg_line_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({shdn_pin_i, sda_i, scl_i}),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];
    assign pin_s = lines_s[2];

    cmdreg_cond_detect u_det (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_s          (scl_s),
        .sda_s          (sda_s),
        .scl_rise       (scl_rise),
        .scl_fall       (scl_fall),
        .start_evt      (start_evt),
        .stop_raw       (stop_raw),
        .stop_ok        (stop_ok),
        .in_start_pulse (in_start_pulse)
    );

    slv_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (stop_ok) begin
            if (cur_q.pend_vld) begin
                nxt_d.cmd = cur_q.pend;
            end
            nxt_d.state    = ST_IDLE;
            nxt_d.drive    = 1'b0;
            nxt_d.pend_vld = 1'b0;
        end else if (start_evt) begin
            nxt_d.state    = ST_ADDR;
            nxt_d.bits     = '0;
            nxt_d.drive    = 1'b0;
            nxt_d.pend_vld = 1'b0;
        end else begin
            unique case (cur_q.state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && cur_q.bits != FULL_BYTE) begin
                        nxt_d.shift = {cur_q.shift[CMD_W-2:0], sda_s};
                        nxt_d.bits  = cur_q.bits + 1'b1;
                        if (cur_q.state == ST_DATA && cur_q.bits == LAST_BIT) begin
                            nxt_d.pend     = {cur_q.shift[CMD_W-2:0], sda_s};
                            nxt_d.pend_vld = 1'b1;
                        end
                    end else if (scl_fall && cur_q.bits == FULL_BYTE) begin
                        if (cur_q.state == ST_DATA) begin
                            nxt_d.drive = 1'b1;
                            nxt_d.state = ST_DATA_ACK;
                        end else if (cur_q.shift[CMD_W-1:1] == OWN_ADDR) begin
                            nxt_d.drive = 1'b1;
                            nxt_d.rd    = cur_q.shift[0];
                            nxt_d.state = ST_ADDR_ACK;
                        end else begin
                            nxt_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        nxt_d.drive = 1'b0;
                        nxt_d.bits  = '0;
                        nxt_d.state = cur_q.rd ? ST_RELEASE : ST_DATA;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        nxt_d.drive = 1'b0;
                        nxt_d.bits  = '0;
                        nxt_d.state = ST_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sda_drive_low_o = cur_q.drive;
    assign shutdown_o      = !(cur_q.cmd[CMD_W-1] && pin_s);
    assign bass_en_o       = cur_q.cmd[CMD_W-2];
    assign volume_o        = cur_q.cmd[VOL_W-1:0];
endmodule

// File: rtl/cmdreg_i2c_checker.sv
module cmdreg_i2c_checker
    import cmdreg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_evt,
    input logic       stop_raw,
    input logic       stop_ok,
    input logic       in_start_pulse,
    input slv_regs_t  cur_q
);
    assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_ok |=> $stable(cur_q.cmd));

    assert_ack_edge_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.drive) |-> !scl_s);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE) |-> !cur_q.drive);

    assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_RELEASE) |-> !cur_q.drive);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (cur_q.state == ST_ADDR && !cur_q.pend_vld && cur_q.bits == '0));

    assert_same_pulse_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_raw && in_start_pulse) |=> (cur_q.state == ST_ADDR));
endmodule

bind cmdreg_i2c_slave cmdreg_i2c_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_s          (scl_s),
    .start_evt      (start_evt),
    .stop_raw       (stop_raw),
    .stop_ok        (stop_ok),
    .in_start_pulse (in_start_pulse),
    .cur_q          (cur_q)
);

// File: tb/sim_cmdreg_i2c_slave.sv
module sim_cmdreg_i2c_slave;

    localparam int QTR = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pin = 1'b1;
    logic       sda_drive_low_o;
    logic       shutdown_o;
    logic       bass_en_o;
    logic [5:0] volume_o;
    logic       sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] model_cmd = 8'h00;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_drive_low_o;

    cmdreg_i2c_slave #(.ADDR_SEL(1'b0)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .sda_drive_low_o (sda_drive_low_o),
        .shdn_pin_i      (pin),
        .shutdown_o      (shutdown_o),
        .bass_en_o       (bass_en_o),
        .volume_o        (volume_o)
    );

    // monitor: pops expected items and compares with the live ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                if (it.kind == 0) act = {shutdown_o, bass_en_o, volume_o};
                else              act = {7'b0, sda_line};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    function automatic logic [7:0] out_word(logic [7:0] c, logic p);
        return {~(c[7] & p), c[6], c[5:0]};
    endfunction

    task automatic push(int kind, logic [7:0] exp, string req);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
        ->chk_ev;
    endtask

    task automatic expect_out(string req);
        push(0, out_word(model_cmd, pin), req);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #(QTR);
        scl_m = 1'b1; #(QTR);
        sda_m = 1'b0; #(QTR);
        scl_m = 1'b0; #(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #(QTR);
        scl_m = 1'b1; #(QTR);
        sda_m = 1'b1; #(QTR);
    endtask

    task automatic start_stop_same_pulse();
        sda_m = 1'b1; #(QTR);
        scl_m = 1'b1; #(QTR);
        sda_m = 1'b0; #(QTR);
        sda_m = 1'b1; #(QTR);
        scl_m = 1'b0; #(QTR);
    endtask

    task automatic send_bit(logic b);
        sda_m = b;    #(QTR);
        scl_m = 1'b1; #(2*QTR);
        scl_m = 1'b0; #(QTR);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // ninth pulse: master releases, line expected low (ack) or high (nack)
    task automatic ack_slot(logic exp_line, string req);
        sda_m = 1'b1; #(QTR);
        scl_m = 1'b1; #(QTR);
        push(1, {7'b0, exp_line}, req);
        #(QTR - 10);
        push(1, {7'b0, exp_line}, req);
        #10;
        scl_m = 1'b0; #(QTR);
    endtask

    task automatic read_byte_ones(string req);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; #(QTR);
            scl_m = 1'b1; #(QTR);
            push(1, 8'h01, req);
            #(QTR);
            scl_m = 1'b0; #(QTR);
        end
    endtask

    task automatic write_frame(logic [7:0] data, string req);
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, req);
        send_byte(data);  ack_slot(1'b0, req);
        bus_stop();
        model_cmd = data;
        expect_out(req);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #42 rst_n = 1'b1;
        #40;
        // R1: reset state
        expect_out("R1");
        push(1, 8'h01, "R1");

        // R2 R4 R5 R11: single write, held until STOP
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R2");
        send_byte(8'hC5); ack_slot(1'b0, "R4");
        expect_out("R5");
        bus_stop();
        model_cmd = 8'hC5;
        expect_out("R5");
        push(0, 8'h45, "R11");

        // R11: pin gating
        pin = 1'b0; #(QTR);
        push(0, 8'hC5, "R11");
        pin = 1'b1; #(QTR);
        push(0, 8'h45, "R11");

        // R3: other address variant is not ours
        bus_start();
        send_byte(8'h9A); ack_slot(1'b1, "R3");
        send_byte(8'h00); ack_slot(1'b1, "R3");
        bus_stop();
        expect_out("R3");

        // R7: read request
        bus_start();
        send_byte(8'h99); ack_slot(1'b0, "R7");
        read_byte_ones("R7");
        send_bit(1'b1);
        bus_stop();
        expect_out("R7");

        // R6: several data bytes
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R6");
        send_byte(8'h01); ack_slot(1'b0, "R6");
        send_byte(8'h7E); ack_slot(1'b0, "R6");
        bus_stop();
        model_cmd = 8'h7E;
        push(0, 8'hFE, "R6");

        // R8: repeated START then a full frame
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R8");
        send_byte(8'h3F); ack_slot(1'b0, "R8");
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R8");
        send_byte(8'h8A); ack_slot(1'b0, "R8");
        bus_stop();
        model_cmd = 8'h8A;
        push(0, 8'h0A, "R8");

        // R8: repeated START discards the pending byte
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R8");
        send_byte(8'h11); ack_slot(1'b0, "R8");
        bus_start();
        send_byte(8'h9A); ack_slot(1'b1, "R8");
        bus_stop();
        expect_out("R8");

        // R9: early STOP mid byte and after address only
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R9");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        expect_out("R9");
        bus_start();
        send_byte(8'h98); ack_slot(1'b0, "R9");
        bus_stop();
        expect_out("R9");
        write_frame(8'hBF, "R9");
        push(0, 8'h3F, "R11");

        // R10: STOP inside the START pulse is ignored
        start_stop_same_pulse();
        send_byte(8'h98); ack_slot(1'b0, "R10");
        send_byte(8'hC0); ack_slot(1'b0, "R10");
        bus_stop();
        model_cmd = 8'hC0;
        push(0, 8'h40, "R10");

        #(QTR);
        ->chk_ev;
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule